// File: doc/BRIEF.md
# DE Gap Sync Regenerator

Some video links carry only a data-enable qualifier and pixel data, with no horizontal or vertical sync pulses. This block rebuilds line and frame boundaries for such links. On every pixel clock it watches the data-enable input. A cycle with data-enable low is an idle pixel, and the block counts how many idle pixels arrive in a row. When that run reaches a programmable line threshold, the block emits a one-cycle line strobe. When the same run reaches a larger programmable frame threshold, it emits a one-cycle frame strobe.

Any cycle with data-enable high ends the run. A valid setup needs a line threshold greater than one and smaller than the frame threshold. If the thresholds break that rule, the block raises an error flag and holds both strobes low. The block is meant to be used only when the incoming stream has no sync pulses of its own.

Top module: `de_sync_regen`

## Requirements
- R1: While `rst` is high at a rising edge, after that edge `line_sync`, `frame_sync` and `cfg_err` are 0 and the idle-run count is 0, so a run in progress before reset does not carry over.
- R2: An idle pixel is a clock cycle with `de_in` = 0. Any cycle with `de_in` = 1 clears the idle-run count to zero, so a later run counts again from one.
- R3: `line_sync` is high for exactly one cycle, right after the rising edge at which the idle pixel that brings the run to `hgap_len` is sampled.
- R4: `frame_sync` is high for exactly one cycle, right after the rising edge at which the idle pixel that brings the run to `vgap_len` is sampled. In a valid setup it is never high in the same cycle as `line_sync`.
- R5: Each strobe fires at most once per idle run. No strobe repeats while the run goes on, and no strobe fires on a cycle whose sampled `de_in` was 1.
- R6: After each rising edge, `cfg_err` is 1 exactly when the thresholds sampled at that edge fail the rule (`hgap_len` > 1 and `hgap_len` < `vgap_len`). Both thresholds are unsigned.
- R7: When the thresholds sampled at an edge are invalid, neither strobe fires after that edge, even if the run length matches a threshold.
- R8: The idle-run count saturates at 2^CNT_W-1 and does not wrap. A run longer than that produces no second strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| de_in | input | 1 | Data-enable qualifier of the incoming pixel |
| hgap_len | input | CNT_W | Idle-run length that produces a line strobe |
| vgap_len | input | CNT_W | Idle-run length that produces a frame strobe |
| line_sync | output | 1 | One-cycle regenerated line strobe |
| frame_sync | output | 1 | One-cycle regenerated frame strobe |
| cfg_err | output | 1 | Threshold ordering rule is violated |

## Verification
Some properties are checked by assertions on every cycle:
- a data-enable cycle always clears the idle-run count;
- the count holds at its ceiling;
- a strobe needs an idle pixel in the sampled cycle and never lasts two cycles;
- the two strobes never coincide;
- an invalid setup silences both strobes.

Other properties only the bench scenarios can show:
- a strobe lands on exactly the run length asked for;
- gaps one short of a threshold stay silent;
- a single data-enable blip restarts the run;
- a run longer than the counter range gives no second strobe;
- the error flag follows each threshold pair, including equal and zero thresholds.

// File: rtl/de_sync_regen_pkg.sv
package de_sync_regen_pkg;

    // Index of each regenerated strobe channel
    typedef enum logic {
        CH_LINE  = 1'b0,
        CH_FRAME = 1'b1
    } sync_ch_e;

    localparam int NUM_CH = 2;

    typedef struct packed {
        logic frame;
        logic line;
    } sync_strobe_t;

    // Ordering rule for the two idle-run thresholds
    function automatic logic thresholds_ok(input logic [31:0] h_thr,
                                           input logic [31:0] v_thr);
        return (h_thr > 32'd1) && (h_thr < v_thr);
    endfunction

endpackage

// File: rtl/de_sync_regen_gap_counter.sv
module de_sync_regen_gap_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             de_in,
    output logic [CNT_W-1:0] run_q
);
    localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] run_d;

    always_comb begin
        if (de_in)
            run_d = '0;
        else if (run_q == RUN_MAX)
            run_d = run_q;
        else
            run_d = run_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else
            run_q <= run_d;
    end

    // R2: a data-enable cycle leaves the run at zero
    a_r2_de_clears: assert property (@(posedge clk) disable iff (rst)
        $past(de_in) |-> (run_q == '0));

    // R8: the count holds at its ceiling instead of wrapping
    a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
        (!$past(de_in) && $past(run_q) == RUN_MAX) |-> (run_q == RUN_MAX));

endmodule

// File: rtl/de_sync_regen_cfg_check.sv
module de_sync_regen_cfg_check
    import de_sync_regen_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] hgap_len,
    input  logic [CNT_W-1:0] vgap_len,
    output logic             cfg_ok,
    output logic             cfg_err_q
);
    logic [31:0] h_ext;
    logic [31:0] v_ext;

    always_comb begin
        h_ext  = 32'(hgap_len);
        v_ext  = 32'(vgap_len);
        cfg_ok = thresholds_ok(h_ext, v_ext);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg_err_q <= 1'b0;
        else
            cfg_err_q <= !cfg_ok;
    end

endmodule

// File: rtl/de_sync_regen_strobe.sv
module de_sync_regen_strobe
    import de_sync_regen_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        de_in,
    input  logic                        enable,
    input  logic [CNT_W-1:0]            run_q,
    input  logic [NUM_CH-1:0][CNT_W-1:0] thr,
    output logic [NUM_CH-1:0]           pulse_q
);
    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
            logic hit;

            // Fires when this idle pixel lifts the run onto the threshold
            always_comb begin
                hit = enable && !de_in && (run_q == (thr[gi] - 1'b1));
            end

            always_ff @(posedge clk) begin
                if (rst)
                    pulse_q[gi] <= 1'b0;
                else
                    pulse_q[gi] <= hit;
            end

            // R5: a strobe needs an idle sampled pixel
            a_r5_needs_idle: assert property (@(posedge clk) disable iff (rst)
                pulse_q[gi] |-> !$past(de_in));

            // R5: a strobe never stays high for two cycles
            a_r5_no_repeat: assert property (@(posedge clk) disable iff (rst)
                pulse_q[gi] |=> !pulse_q[gi]);
        end
    endgenerate

endmodule

// File: rtl/de_sync_regen.sv
module de_sync_regen
    import de_sync_regen_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             de_in,
    input  logic [CNT_W-1:0] hgap_len,
    input  logic [CNT_W-1:0] vgap_len,
    output logic             line_sync,
    output logic             frame_sync,
    output logic             cfg_err
);
    logic [CNT_W-1:0]             run_q;
    logic                         cfg_ok;
    logic [NUM_CH-1:0][CNT_W-1:0] thr;
    logic [NUM_CH-1:0]            pulse_q;
    sync_strobe_t                 strobes;

    always_comb begin
        thr[CH_LINE]  = hgap_len;
        thr[CH_FRAME] = vgap_len;
        strobes.line  = pulse_q[CH_LINE];
        strobes.frame = pulse_q[CH_FRAME];
        line_sync     = strobes.line;
        frame_sync    = strobes.frame;
    end

    de_sync_regen_gap_counter #(.CNT_W(CNT_W)) u_counter (
        .clk   (clk),
        .rst   (rst),
        .de_in (de_in),
        .run_q (run_q)
    );

    de_sync_regen_cfg_check #(.CNT_W(CNT_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .hgap_len  (hgap_len),
        .vgap_len  (vgap_len),
        .cfg_ok    (cfg_ok),
        .cfg_err_q (cfg_err)
    );

    de_sync_regen_strobe #(.CNT_W(CNT_W)) u_strobe (
        .clk     (clk),
        .rst     (rst),
        .de_in   (de_in),
        .enable  (cfg_ok),
        .run_q   (run_q),
        .thr     (thr),
        .pulse_q (pulse_q)
    );

    // R7: an invalid threshold pair silences both strobes
    a_r7_suppress: assert property (@(posedge clk) disable iff (rst)
        !cfg_ok |=> (!line_sync && !frame_sync));

    // R4: line and frame strobes never coincide
    a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(line_sync && frame_sync));

    // R1: the cycle after reset is quiet
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!line_sync && !frame_sync && !cfg_err));

endmodule

// File: tb/de_sync_regen_bench.sv
`timescale 1ns/1ps
module de_sync_regen_bench;
    localparam int CNT_W = 12;
    localparam int WATCHDOG = 150000;

    typedef struct packed {
        logic        de;
        logic [15:0] len;
        logic [11:0] h;
        logic [11:0] v;
    } seg_t;

    localparam int NSEG = 22;
    localparam seg_t SEGS [NSEG] = '{
        '{1'b1, 16'd3,    12'd4, 12'd10},
        '{1'b0, 16'd3,    12'd4, 12'd10},   // one short of line: silent
        '{1'b1, 16'd2,    12'd4, 12'd10},
        '{1'b0, 16'd4,    12'd4, 12'd10},   // line on 4th idle pixel
        '{1'b1, 16'd1,    12'd4, 12'd10},
        '{1'b0, 16'd12,   12'd4, 12'd10},   // line then frame
        '{1'b1, 16'd5,    12'd2, 12'd3},
        '{1'b0, 16'd6,    12'd2, 12'd3},    // smallest valid line threshold
        '{1'b1, 16'd2,    12'd1, 12'd3},    // h = 1 invalid
        '{1'b0, 16'd5,    12'd1, 12'd3},
        '{1'b0, 16'd3,    12'd5, 12'd5},    // equal invalid
        '{1'b1, 16'd1,    12'd6, 12'd4},    // h > v invalid
        '{1'b0, 16'd8,    12'd6, 12'd4},
        '{1'b1, 16'd1,    12'd3, 12'd7},
        '{1'b0, 16'd2,    12'd3, 12'd7},
        '{1'b1, 16'd1,    12'd3, 12'd7},    // blip restarts run
        '{1'b0, 16'd3,    12'd3, 12'd7},
        '{1'b0, 16'd20,   12'd3, 12'd7},    // long gap: no repeats
        '{1'b1, 16'd2,    12'd3, 12'd4095},
        '{1'b0, 16'd5000, 12'd3, 12'd4095}, // past counter range
        '{1'b1, 16'd3,    12'd0, 12'd0},
        '{1'b0, 16'd3,    12'd0, 12'd0}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             de_in = 1'b1;
    logic [CNT_W-1:0] hgap_len = 12'd4;
    logic [CNT_W-1:0] vgap_len = 12'd10;
    logic             line_sync;
    logic             frame_sync;
    logic             cfg_err;

    int checks = 0;
    int errors = 0;
    int run = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    de_sync_regen #(.CNT_W(CNT_W)) u_de_sync_regen (
        .clk        (clk),
        .rst        (rst),
        .de_in      (de_in),
        .hgap_len   (hgap_len),
        .vgap_len   (vgap_len),
        .line_sync  (line_sync),
        .frame_sync (frame_sync),
        .cfg_err    (cfg_err)
    );

    task automatic check(input logic ok, input string tag,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d",
                     tag, cyc, act, exp);
        end
    endtask

    // One pixel clock with model update and per-cycle checks
    task automatic step(input logic d, input logic r);
        logic valid;
        logic exp_line;
        logic exp_frame;
        @(negedge clk);
        de_in = d;
        rst = r;
        @(posedge clk);
        #1;
        cyc++;
        if (r || d) run = 0;
        else run = run + 1;
        valid = (int'(hgap_len) > 1) && (int'(hgap_len) < int'(vgap_len));
        exp_line  = !r && valid && !d && (run == int'(hgap_len));
        exp_frame = !r && valid && !d && (run == int'(vgap_len));
        check(line_sync == exp_line, "R3 R5 R7 R8 line_sync",
              int'(line_sync), int'(exp_line));
        check(frame_sync == exp_frame, "R4 R5 R7 R8 frame_sync",
              int'(frame_sync), int'(exp_frame));
        check(cfg_err == (!r && !valid), "R6 cfg_err",
              int'(cfg_err), int'(!r && !valid));
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual %0d expected %0d", WATCHDOG, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int lines_seen;
        // R1: reset state
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        check(!line_sync && !frame_sync && !cfg_err, "R1 reset outputs",
              int'({line_sync, frame_sync, cfg_err}), 0);

        foreach (SEGS[i]) begin
            hgap_len = SEGS[i].h;
            vgap_len = SEGS[i].v;
            for (int k = 0; k < int'(SEGS[i].len); k++)
                step(SEGS[i].de, 1'b0);
        end

        // R1: reset mid-gap clears the run
        hgap_len = 12'd4;
        vgap_len = 12'd9;
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        lines_seen = 0;
        for (int k = 0; k < 3; k++) begin
            step(1'b0, 1'b0);
            lines_seen += int'(line_sync);
        end
        check(lines_seen == 0, "R1 run cleared by reset", lines_seen, 0);
        step(1'b0, 1'b0);
        check(line_sync == 1'b1, "R1 R3 line after fresh run",
              int'(line_sync), 1);

        // R2: one data-enable blip inside an otherwise long gap
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        lines_seen = 0;
        for (int k = 0; k < 3; k++) begin
            step(1'b0, 1'b0);
            lines_seen += int'(line_sync);
        end
        check(lines_seen == 0, "R2 blip restarts count", lines_seen, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule